// File: doc/BRIEF.md
# PCM Time Slot Strobe Generator

This block picks out a programmable group of bit positions inside a PCM frame and raises a per-bit enable while those positions pass. A serial channel's receiver and transmitter can then be gated onto them. Both directions share one bit clock and one frame sync pulse. Each direction has its own start position, its own window width and its own optional octet mask. A shared mode bit chooses between one window per frame sync and a free-running repeat.

On each frame sync the block samples the configuration for both directions. It computes a start delay D = slot*8 + shift + 1, which lies between 1 and 1024 bit clocks. It then preloads an offset counter with 1024 - D. When that counter reaches its top value, it starts a duration counter that shapes the strobe. Without the mask, the window lasts width+1 bit clocks. With the mask, the window lasts 32 octets and each octet's strobe follows one mask bit.

Top module: `pcm_slot_assigner`

## Requirements
- R1: After reset, both strobes are low and stay low until the first frame sync, whatever the configuration inputs do.
- R2: With fsync high at bit clock edge E0 and the mask off, the strobe is first high after edge E(D+1), where D = slot*8 + shift + 1 (1..1024).
- R3: With the mask off, the strobe stays high for exactly width+1 consecutive bit clocks (width 0..255) and is never high outside a running window.
- R4: With the mask enabled, the window lasts 256 bit clocks. Window bit j (counted from 0) is strobed exactly when mask bit floor(j/8) is 1, so mask bit 0 is the first octet.
- R5: With mode 0 (free running), windows start D, 2D, 3D, ... bit clocks after E0 without further frame syncs. A window start that comes while a window is still running restarts that window from bit 0.
- R6: With mode 1 (one shot), exactly one window follows each frame sync, and the counter then waits for the next frame sync.
- R7: A frame sync that arrives during a window ends the window: the strobe is low after the second edge following the sync, and timing restarts from the new sync.
- R8: Changes to the configuration inputs between frame syncs have no effect until the next frame sync.
- R9: The receive and transmit strobes are timed independently, each from its own slot, shift, width, mask enable and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync pulse, one bit clock wide |
| frame_mode | input | 1 | 0 free running, 1 one window per sync |
| rx_slot | input | 7 | Receive start slot number |
| rx_shift | input | 3 | Receive extra bit shift |
| rx_width | input | 8 | Receive window length minus one (mask off) |
| rx_mask_en | input | 1 | Receive octet mask enable |
| rx_mask | input | 32 | Receive octet mask, bit 0 first octet |
| tx_slot | input | 7 | Transmit start slot number |
| tx_shift | input | 3 | Transmit extra bit shift |
| tx_width | input | 8 | Transmit window length minus one (mask off) |
| tx_mask_en | input | 1 | Transmit octet mask enable |
| tx_mask | input | 32 | Transmit octet mask, bit 0 first octet |
| rx_strobe | output | 1 | Receive per-bit enable |
| tx_strobe | output | 1 | Transmit per-bit enable |

## Verification
The properties assume that fsync is a pulse on the bit clock and that nothing outside reset forces the window state. They also read the mode from the copy latched at the sync, not from the live input, so they make no assumption about when software changes the mode. The stimulus always presents a new configuration in the same cycle as fsync. In the runs that exercise R8, it changes the inputs in the cycles that follow the sync, so that the expected strobes, which come only from the values present at the sync, reveal any leak.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;
  typedef enum logic {
    TSA_FREE_RUN = 1'b0,
    TSA_ONE_SHOT = 1'b1
  } tsa_mode_e;

  localparam int unsigned TSA_OCTET_BITS = 8;
endpackage

// File: rtl/tsa_offset_ctr.sv
module tsa_offset_ctr #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             one_shot,
  output logic             start
);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] LAST = TOP - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // the counter parks at TOP when idle; a sync always wins
  assign start = (cnt_q == LAST) && !fsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TOP;
    end else if (fsync) begin
      cnt_q <= load_val;
    end else if (start) begin
      cnt_q <= one_shot ? TOP : reload_val;
    end else if (cnt_q != TOP) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tsa_window.sv
module tsa_window #(
  parameter int unsigned MASK_SLOTS = 32,
  parameter int unsigned OCT_BITS   = 8,
  parameter int unsigned DUR_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  start,
  input  logic [DUR_W-1:0]      last_idx,
  input  logic                  mask_en,
  input  logic [MASK_SLOTS-1:0] mask,
  output logic                  busy,
  output logic                  strobe
);
  localparam int unsigned OCT_W = $clog2(OCT_BITS);
  localparam int unsigned IDX_W = DUR_W - OCT_W;

  logic [DUR_W-1:0] dcnt_q;
  logic             bit_sel;

  function automatic logic octet_pick(input logic [MASK_SLOTS-1:0] m,
                                      input logic [DUR_W-1:0] pos);
    logic [IDX_W-1:0] oct;
    oct = pos[DUR_W-1:OCT_W];
    return m[oct];
  endfunction

  assign bit_sel = mask_en ? octet_pick(mask, dcnt_q) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      dcnt_q <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= busy && bit_sel;
      if (fsync) begin
        busy <= 1'b0;
      end else if (start) begin
        busy   <= 1'b1;
        dcnt_q <= '0;
      end else if (busy) begin
        if (dcnt_q == last_idx) busy <= 1'b0;
        else                    dcnt_q <= dcnt_q + DUR_W'(1);
      end
    end
  end
endmodule

// File: rtl/tsa_channel.sv
module tsa_channel
  import pcm_tsa_pkg::*;
#(
  parameter int unsigned SLOT_W     = 7,
  parameter int unsigned SHIFT_W    = 3,
  parameter int unsigned WID_W      = 8,
  parameter int unsigned MASK_SLOTS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  tsa_mode_e             mode,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [SHIFT_W-1:0]    shift,
  input  logic [WID_W-1:0]      width,
  input  logic                  mask_en,
  input  logic [MASK_SLOTS-1:0] mask,
  output logic                  start,
  output logic                  busy,
  output logic                  one_shot,
  output logic                  strobe
);
  localparam int unsigned CNT_W = SLOT_W + SHIFT_W + 1;
  localparam int unsigned DUR_W = $clog2(MASK_SLOTS * TSA_OCTET_BITS);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(1) << (CNT_W - 1);
  localparam logic [DUR_W-1:0] MASK_LAST = DUR_W'(MASK_SLOTS * TSA_OCTET_BITS - 1);

  // start delay in bit clocks, 1 .. 2**(SLOT_W+SHIFT_W)
  function automatic logic [CNT_W-1:0] delay_of(input logic [SLOT_W-1:0] s,
                                                input logic [SHIFT_W-1:0] b);
    return {1'b0, s, b} + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0]      load_val, reload_q;
  logic                  mask_en_q, one_shot_q;
  logic [MASK_SLOTS-1:0] mask_q;
  logic [WID_W-1:0]      width_q;
  logic [DUR_W-1:0]      last_idx;

  assign load_val = TOP - delay_of(slot, shift);
  assign last_idx = mask_en_q ? MASK_LAST : DUR_W'(width_q);
  assign one_shot = one_shot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q   <= TOP;
      mask_en_q  <= 1'b0;
      one_shot_q <= 1'b1;
      mask_q     <= '0;
      width_q    <= '0;
    end else if (fsync) begin
      reload_q   <= load_val;
      mask_en_q  <= mask_en;
      one_shot_q <= (mode == TSA_ONE_SHOT);
      mask_q     <= mask;
      width_q    <= width;
    end
  end

  tsa_offset_ctr #(.CNT_W(CNT_W)) u_off (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .load_val(load_val), .reload_val(reload_q),
    .one_shot(one_shot_q), .start(start)
  );

  tsa_window #(.MASK_SLOTS(MASK_SLOTS), .OCT_BITS(TSA_OCTET_BITS), .DUR_W(DUR_W)) u_win (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .start(start),
    .last_idx(last_idx), .mask_en(mask_en_q), .mask(mask_q),
    .busy(busy), .strobe(strobe)
  );
endmodule

// File: rtl/pcm_slot_assigner.sv
module pcm_slot_assigner
  import pcm_tsa_pkg::*;
#(
  parameter int unsigned SLOT_W     = 7,
  parameter int unsigned SHIFT_W    = 3,
  parameter int unsigned WID_W      = 8,
  parameter int unsigned MASK_SLOTS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  frame_mode,
  input  logic [SLOT_W-1:0]     rx_slot,
  input  logic [SHIFT_W-1:0]    rx_shift,
  input  logic [WID_W-1:0]      rx_width,
  input  logic                  rx_mask_en,
  input  logic [MASK_SLOTS-1:0] rx_mask,
  input  logic [SLOT_W-1:0]     tx_slot,
  input  logic [SHIFT_W-1:0]    tx_shift,
  input  logic [WID_W-1:0]      tx_width,
  input  logic                  tx_mask_en,
  input  logic [MASK_SLOTS-1:0] tx_mask,
  output logic                  rx_strobe,
  output logic                  tx_strobe
);
  localparam int unsigned NPATH = 2;

  logic [SLOT_W-1:0]     slot_a  [NPATH];
  logic [SHIFT_W-1:0]    shift_a [NPATH];
  logic [WID_W-1:0]      width_a [NPATH];
  logic [MASK_SLOTS-1:0] mask_a  [NPATH];
  logic [NPATH-1:0]      mask_en_a;

  // per-path events, named for the checker
  logic [NPATH-1:0] win_start, win_busy, win_one_shot, win_strobe;

  tsa_mode_e mode;
  assign mode = tsa_mode_e'(frame_mode);

  assign slot_a[0]  = rx_slot;   assign slot_a[1]  = tx_slot;
  assign shift_a[0] = rx_shift;  assign shift_a[1] = tx_shift;
  assign width_a[0] = rx_width;  assign width_a[1] = tx_width;
  assign mask_a[0]  = rx_mask;   assign mask_a[1]  = tx_mask;
  assign mask_en_a  = {tx_mask_en, rx_mask_en};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    tsa_channel #(
      .SLOT_W(SLOT_W), .SHIFT_W(SHIFT_W), .WID_W(WID_W), .MASK_SLOTS(MASK_SLOTS)
    ) u_chan (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode(mode),
      .slot(slot_a[p]), .shift(shift_a[p]), .width(width_a[p]),
      .mask_en(mask_en_a[p]), .mask(mask_a[p]),
      .start(win_start[p]), .busy(win_busy[p]),
      .one_shot(win_one_shot[p]), .strobe(win_strobe[p])
    );
  end

  assign rx_strobe = win_strobe[0];
  assign tx_strobe = win_strobe[1];
endmodule

// File: rtl/pcm_slot_assigner_chk.sv
module pcm_slot_assigner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fsync,
  input logic [1:0] win_start,
  input logic [1:0] win_busy,
  input logic [1:0] win_one_shot,
  input logic [1:0] win_strobe
);
  for (genvar p = 0; p < 2; p++) begin : g_chk
    // R3
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_strobe[p] |-> $past(win_busy[p]));
    // R7
    sync_ends_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> !win_busy[p]);
    // R7
    sync_quiets_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> ##1 !win_strobe[p]);
    // R2
    start_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_start[p] |=> win_busy[p]);
    // R6
    one_shot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start[p] && win_one_shot[p]) |=> !win_start[p]);
  end
endmodule

bind pcm_slot_assigner pcm_slot_assigner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync),
  .win_start(win_start), .win_busy(win_busy),
  .win_one_shot(win_one_shot), .win_strobe(win_strobe)
);

// File: tb/pcm_slot_assigner_tb_top.sv
module pcm_slot_assigner_tb_top;
  typedef struct {
    int           slot;
    int           shift;
    int           width;
    bit           men;
    logic [31:0]  mask;
  } pcfg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        frame_mode = 1'b1;
  logic [6:0]  rx_slot = '0, tx_slot = '0;
  logic [2:0]  rx_shift = '0, tx_shift = '0;
  logic [7:0]  rx_width = '0, tx_width = '0;
  logic        rx_mask_en = 1'b0, tx_mask_en = 1'b0;
  logic [31:0] rx_mask = '0, tx_mask = '0;
  logic        rx_strobe, tx_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10ns clk = ~clk;

  pcm_slot_assigner dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .frame_mode(frame_mode),
    .rx_slot(rx_slot), .rx_shift(rx_shift), .rx_width(rx_width),
    .rx_mask_en(rx_mask_en), .rx_mask(rx_mask),
    .tx_slot(tx_slot), .tx_shift(tx_shift), .tx_width(tx_width),
    .tx_mask_en(tx_mask_en), .tx_mask(tx_mask),
    .rx_strobe(rx_strobe), .tx_strobe(tx_strobe)
  );

  function automatic pcfg_t mk(int s, int b, int w, bit me, logic [31:0] m);
    pcfg_t c;
    c.slot = s; c.shift = b; c.width = w; c.men = me; c.mask = m;
    return c;
  endfunction

  function automatic int dly(pcfg_t c);
    return c.slot * 8 + c.shift + 1;
  endfunction

  function automatic int wlen(pcfg_t c);
    return c.men ? 256 : c.width + 1;
  endfunction

  // expected strobe after the n-th edge following the sync edge
  function automatic bit expect_at(int n, pcfg_t c, bit free_run);
    int d, j;
    d = dly(c);
    if (!free_run) begin
      j = n - (d + 1);
    end else begin
      if (n - 1 < d) return 1'b0;
      j = (n - 1) - ((n - 1) / d) * d;
    end
    if (j < 0 || j >= wlen(c)) return 1'b0;
    return c.men ? c.mask[j / 8] : 1'b1;
  endfunction

  task automatic check_bit(logic act, bit exp, string tag, string path, int n);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: strobe=%b expected %b", tag, path, n, act, exp);
    end
  endtask

  task automatic drive(pcfg_t r, pcfg_t t);
    rx_slot = 7'(r.slot); rx_shift = 3'(r.shift); rx_width = 8'(r.width);
    rx_mask_en = r.men;   rx_mask = r.mask;
    tx_slot = 7'(t.slot); tx_shift = 3'(t.shift); tx_width = 8'(t.width);
    tx_mask_en = t.men;   tx_mask = t.mask;
  endtask

  task automatic run_frame(pcfg_t r, pcfg_t t, bit free_run, int ncyc,
                           bit scramble, string tag);
    @(negedge clk);
    drive(r, t);
    frame_mode = !free_run;
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    if (scramble) begin
      // R8: these values must not reach the running frame
      drive(mk((r.slot + 9) % 128, 7 - r.shift, 255 - r.width, !r.men, ~r.mask),
            mk((t.slot + 3) % 128, 7 - t.shift, 255 - t.width, !t.men, ~t.mask));
      frame_mode = free_run;
    end
    for (int n = 1; n <= ncyc; n++) begin
      @(negedge clk);
      check_bit(rx_strobe, expect_at(n, r, free_run), tag, "rx", n);
      check_bit(tx_strobe, expect_at(n, t, free_run), tag, "tx+R9", n);
    end
  endtask

  task automatic one_shot_run(pcfg_t r, pcfg_t t, bit scramble, string tag);
    int a, b;
    a = dly(r) + wlen(r);
    b = dly(t) + wlen(t);
    run_frame(r, t, 1'b0, ((a > b) ? a : b) + 40, scramble, tag);
  endtask

  initial begin
    int slots [3] = '{0, 3, 127};
    int widths [3] = '{0, 9, 255};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle before the first sync even while inputs move
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      drive(mk(n % 4, n % 8, n, n[0], 32'hFFFF_FFFF), mk(0, 0, 200, 1'b0, '1));
      frame_mode = n[1];
      check_bit(rx_strobe, 1'b0, "R1", "rx", n);
      check_bit(tx_strobe, 1'b0, "R1", "tx", n);
    end
    // R2 R3 R6: one-shot sweep over start position and width
    foreach (slots[i]) for (int b = 0; b < 8; b += 7) foreach (widths[k]) begin
      one_shot_run(mk(slots[i], b, widths[k], 1'b0, '0),
                   mk((slots[i] + 1) % 128, 7 - b, (widths[k] + 4) % 256, 1'b0, '0),
                   1'b0, "R2 R3 R6");
    end
    // R4: octet masks
    one_shot_run(mk(0, 0, 0, 1'b1, 32'h0000_0001), mk(2, 5, 3, 1'b1, 32'h8000_0001), 1'b0, "R4");
    one_shot_run(mk(1, 3, 0, 1'b1, 32'hA5C3_0F96), mk(0, 0, 17, 1'b0, '0), 1'b0, "R4");
    one_shot_run(mk(5, 2, 0, 1'b1, 32'h0000_0000), mk(4, 4, 0, 1'b1, 32'hFFFF_FFFF), 1'b0, "R4");
    // R5: free-running repeat, including restart of an unfinished window
    run_frame(mk(1, 7, 3, 1'b0, '0), mk(1, 0, 20, 1'b0, '0), 1'b1, 300, 1'b0, "R5");
    run_frame(mk(0, 0, 5, 1'b0, '0), mk(4, 7, 0, 1'b1, 32'h0000_0005), 1'b1, 300, 1'b0, "R5");
    run_frame(mk(127, 7, 7, 1'b0, '0), mk(100, 1, 255, 1'b0, '0), 1'b1, 2100, 1'b0, "R5");
    // R8: inputs change right after the sync
    one_shot_run(mk(2, 1, 12, 1'b0, '0), mk(3, 6, 0, 1'b1, 32'h0000_00F3), 1'b1, "R8");
    run_frame(mk(2, 2, 6, 1'b0, '0), mk(1, 1, 2, 1'b0, '0), 1'b1, 200, 1'b1, "R8");
    // R7: sync during a running window, then a fresh frame
    run_frame(mk(0, 2, 100, 1'b0, '0), mk(0, 0, 150, 1'b0, '0), 1'b0, 20, 1'b0, "R7");
    one_shot_run(mk(1, 0, 4, 1'b0, '0), mk(0, 5, 2, 1'b0, '0), 1'b0, "R7");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule